// File: doc/BRIEF.md
# DMA Transfer Timing Sequencer

This block runs the active part of a DMA service for one channel that has already been selected by the priority logic. When the selected channel requests service, the sequencer takes a snapshot of that channel's working context: the current and reload address and count, the service mode, the address direction, the transfer direction and the autoinitialize and memory-to-memory options. It then raises a hold request and waits for the processor to acknowledge it. After that it steps through the working cycles that drive the bus strobes, the address-enable signal and the address strobe. The low address byte is driven directly. The high address byte is placed on the data-bus output for one cycle so that an external latch can capture it.

Each transfer moves the address one step up or down and lowers the count by one. A count that passes from zero to all ones is the terminal count. The terminal count pulses the end-of-process output low and ends the service. A low on the end-of-process input ends the service in the same way. When the service finishes, the block pulses a writeback port. The port carries the updated address and count, or the reload values if autoinitialize applies, and flags that ask the register block to mask the channel and set its terminal-count status. A memory-to-memory copy uses eight cycles per transfer. The read half captures a byte into a temporary register, and the write half drives that byte back out.

Top module: `dma_xfer_seq`

## Requirements
- R1: While and directly after reset, hrq and aen are low, adstb and db_oe are low, all four strobes (memr_n, memw_n, ior_n, iow_n) and eop_out_n are high, dack is all zero and wb_valid is low.
- R2: A request (dreq high) seen while idle raises hrq from the next cycle on, and hrq stays high until the service ends. The first working cycle (aen high) begins only in the cycle after hlda has been sampled high, and aen stays low while hlda is low.
- R3: The first cycle of every normal transfer has adstb high, aen high, the upper address byte on db_out with db_oe high, and the lower address byte on addr_lo. The dack bit with the index of the snapshotted channel is high, active high, during all four working cycles.
- R4: In a normal transfer the read-side strobe is low in working cycles 2 to 4 and the write-side strobe is low in cycles 3 and 4. to_mem=1 selects ior_n as the read side and memw_n as the write side. to_mem=0 selects memr_n and iow_n.
- R5: A low ready input during the third working cycle of a normal transfer, or the third cycle of either half of a memory-to-memory transfer, repeats that cycle with its strobes held, until ready is seen high.
- R6: Each transfer lowers the count by one and moves the address by one: up when addr_dec=0, down when addr_dec=1.
- R7: A transfer that starts with a count of zero is the terminal count. eop_out_n is low for exactly its final working cycle, the count becomes all ones, and the service ends.
- R8: One cycle after the final working cycle of a service, wb_valid pulses with wb_addr, wb_cnt and wb_src. If the service ended by terminal count or external end-of-process and auto_init=1, these are the reload values and set_mask and set_tc stay low. Otherwise they are the updated values, and set_mask and set_tc are high exactly when the service ended by an end-of-process event.
- R9: Single mode (svc_mode=01) performs one transfer per service, then goes idle with hrq low for at least one cycle, even while dreq stays high.
- R10: Block mode (svc_mode=10 or 11) keeps transferring after dreq falls, until terminal count or external end-of-process.
- R11: Demand mode (svc_mode=00) ends the service after the current transfer when dreq is low in the third working cycle. The updated address and count are written back with set_mask low.
- R12: eop_in_n low in any working cycle ends the service after the current transfer. It is treated as an end-of-process event, and eop_out_n is not driven for it.
- R13: A memory-to-memory service (mem2mem=1) runs eight cycles per transfer. In the read half, adstb is high with the source address, and memr_n is low in cycles 2 to 4, with db_in captured in cycle 4. In the write half, adstb is high with the destination address, and the captured byte is on db_out in cycles 2 to 4, with memw_n low in cycles 3 and 4. dack stays zero.
- R14: In a memory-to-memory service the count belongs to the destination channel 1. eop_out_n pulses at the end of that count's terminal write half, wb_ch is 1 and wb_src carries the updated source address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq | input | 1 | Request of the selected channel, active high |
| chan | input | 2 | Index of the selected channel |
| svc_mode | input | 2 | 00 demand, 01 single, 10/11 block |
| addr_dec | input | 1 | 1 steps the address down |
| auto_init | input | 1 | Reload on end-of-process |
| mem2mem | input | 1 | Memory-to-memory copy |
| to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| cur_addr | input | 16 | Current address (destination for copies) |
| cur_cnt | input | 16 | Current count |
| base_addr | input | 16 | Reload address |
| base_cnt | input | 16 | Reload count |
| src_addr | input | 16 | Copy source current address |
| src_base | input | 16 | Copy source reload address |
| hlda | input | 1 | Hold acknowledge |
| ready | input | 1 | Low adds wait cycles |
| eop_in_n | input | 1 | External end-of-process, active low |
| db_in | input | 8 | Data bus input |
| hrq | output | 1 | Hold request |
| aen | output | 1 | Address enable |
| adstb | output | 1 | Upper-address strobe |
| db_out | output | 8 | Data bus output |
| db_oe | output | 1 | Data bus output enable |
| addr_lo | output | 8 | Lower address byte |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | Peripheral read strobe |
| iow_n | output | 1 | Peripheral write strobe |
| dack | output | 4 | Channel acknowledge, one-hot |
| eop_out_n | output | 1 | Terminal-count pulse, active low |
| wb_valid | output | 1 | Writeback pulse |
| wb_ch | output | 2 | Writeback channel |
| wb_addr | output | 16 | Written-back address |
| wb_cnt | output | 16 | Written-back count |
| wb_src | output | 16 | Written-back copy source address |
| set_mask | output | 1 | Mask the channel |
| set_tc | output | 1 | Set terminal-count status |

## Verification
A stuck or misrouted state register shows up within one cycle on the pins. Either adstb fails to appear in the first working cycle, or a strobe starts one cycle early or late relative to the cycle count from hlda. A wrong address or count register is not visible on the strobes. It appears on addr_lo and db_out in the next transfer's first cycle, and it also shows in the writeback values one cycle after the service ends. A wrong termination decision shows up in the cycle after the final working cycle, as a missing or early wb_valid, a wrong flag, or a hold request that persists.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HOLD,
      ST_W1, ST_W2, ST_W3, ST_W4,
      ST_R1, ST_R2, ST_R3, ST_R4,
      ST_D1, ST_D2, ST_D3, ST_D4
   } seq_state_e;

   typedef enum logic [1:0] {
      SVC_DEMAND = 2'd0,
      SVC_SINGLE = 2'd1,
      SVC_BLOCK  = 2'd2,
      SVC_BLOCK2 = 2'd3
   } svc_mode_e;

   function automatic logic is_work(seq_state_e s);
      return (s != ST_IDLE) && (s != ST_HOLD);
   endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       dreq,
   input  logic       hlda,
   input  logic       ready,
   input  logic       m2m_r,
   input  logic       svc_end,
   output seq_state_e state_q,
   output logic       ld
);

   seq_state_e state_d;

   assign ld = (state_q == ST_IDLE) && dreq;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (dreq) state_d = ST_HOLD;
         ST_HOLD: if (hlda) state_d = m2m_r ? ST_R1 : ST_W1;
         ST_W1:   state_d = ST_W2;
         ST_W2:   state_d = ST_W3;
         ST_W3:   if (ready) state_d = ST_W4;
         ST_W4:   state_d = svc_end ? ST_IDLE : ST_W1;
         ST_R1:   state_d = ST_R2;
         ST_R2:   state_d = ST_R3;
         ST_R3:   if (ready) state_d = ST_R4;
         ST_R4:   state_d = ST_D1;
         ST_D1:   state_d = ST_D2;
         ST_D2:   state_d = ST_D3;
         ST_D3:   if (ready) state_d = ST_D4;
         ST_D4:   state_d = svc_end ? ST_IDLE : ST_R1;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

endmodule

// File: rtl/dma_seq_path.sv
module dma_seq_path
   import dma_seq_pkg::*;
#(
   parameter int DBW = 8,
   parameter int CW  = 16,
   parameter int NCH = 4,
   localparam int AW   = 2 * DBW,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst,
   input  seq_state_e      state_q,
   input  logic            ld,
   input  logic            dreq,
   input  logic            eop_in_n,
   input  logic [DBW-1:0]  db_in,
   input  logic [CH_W-1:0] chan,
   input  logic [1:0]      svc_mode,
   input  logic            addr_dec,
   input  logic            auto_init,
   input  logic            mem2mem,
   input  logic            to_mem,
   input  logic [AW-1:0]   cur_addr,
   input  logic [CW-1:0]   cur_cnt,
   input  logic [AW-1:0]   base_addr,
   input  logic [CW-1:0]   base_cnt,
   input  logic [AW-1:0]   src_addr,
   input  logic [AW-1:0]   src_base,
   output logic            m2m_r,
   output logic            to_mem_r,
   output logic [CH_W-1:0] ch_r,
   output logic [AW-1:0]   addr_r,
   output logic [AW-1:0]   src_r,
   output logic [DBW-1:0]  temp_r,
   output logic            tc_now,
   output logic            svc_end,
   output logic            wb_valid,
   output logic [CH_W-1:0] wb_ch,
   output logic [AW-1:0]   wb_addr,
   output logic [CW-1:0]   wb_cnt,
   output logic [AW-1:0]   wb_src,
   output logic            set_mask,
   output logic            set_tc
);

   logic [CW-1:0] cnt_r, bcnt_r, cnt_nx;
   logic [AW-1:0] baddr_r, bsrc_r, addr_nx, src_nx;
   svc_mode_e     mode_r;
   logic          dec_r, auto_r, ext_r, dq_r;
   logic          last_ph, eop_hit, mode_end;

   assign last_ph  = (state_q == ST_W4) || (state_q == ST_D4);
   assign tc_now   = (cnt_r == '0);
   assign eop_hit  = tc_now || ext_r || !eop_in_n;
   assign mode_end = !m2m_r &&
                     ((mode_r == SVC_SINGLE) || ((mode_r == SVC_DEMAND) && !dq_r));
   assign svc_end  = last_ph && (eop_hit || mode_end);

   assign cnt_nx  = cnt_r - 1'b1;
   assign addr_nx = dec_r ? addr_r - 1'b1 : addr_r + 1'b1;
   assign src_nx  = dec_r ? src_r  - 1'b1 : src_r  + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         m2m_r <= 1'b0;  to_mem_r <= 1'b0; ch_r <= '0;
         addr_r <= '0;   src_r <= '0;      temp_r <= '0;
         cnt_r <= '0;    bcnt_r <= '0;     baddr_r <= '0; bsrc_r <= '0;
         mode_r <= SVC_DEMAND; dec_r <= 1'b0; auto_r <= 1'b0;
         ext_r <= 1'b0;  dq_r <= 1'b1;
         wb_valid <= 1'b0; wb_ch <= '0; wb_addr <= '0; wb_cnt <= '0; wb_src <= '0;
         set_mask <= 1'b0; set_tc <= 1'b0;
      end else begin
         wb_valid <= 1'b0;
         set_mask <= 1'b0;
         set_tc   <= 1'b0;
         if (ld) begin
            m2m_r <= mem2mem;   to_mem_r <= to_mem; ch_r <= chan;
            addr_r <= cur_addr; src_r <= src_addr;  cnt_r <= cur_cnt;
            baddr_r <= base_addr; bsrc_r <= src_base; bcnt_r <= base_cnt;
            mode_r <= svc_mode_e'(svc_mode);
            dec_r <= addr_dec; auto_r <= auto_init;
            ext_r <= 1'b0; dq_r <= 1'b1;
         end
         if (is_work(state_q) && !eop_in_n) ext_r <= 1'b1;
         if (state_q == ST_W3) dq_r <= dreq;
         if (state_q == ST_R4) temp_r <= db_in;
         if (last_ph) begin
            addr_r <= addr_nx;
            cnt_r  <= cnt_nx;
            if (m2m_r) src_r <= src_nx;
            if (svc_end) begin
               wb_valid <= 1'b1;
               wb_ch    <= m2m_r ? CH_W'(1) : ch_r;
               if (eop_hit && auto_r) begin
                  wb_addr <= baddr_r; wb_cnt <= bcnt_r; wb_src <= bsrc_r;
               end else begin
                  wb_addr <= addr_nx; wb_cnt <= cnt_nx;
                  wb_src  <= m2m_r ? src_nx : src_r;
               end
               set_mask <= eop_hit && !auto_r;
               set_tc   <= eop_hit && !auto_r;
            end
         end
      end
   end

endmodule

// File: rtl/dma_seq_pins.sv
module dma_seq_pins
   import dma_seq_pkg::*;
#(
   parameter int DBW = 8,
   parameter int NCH = 4,
   localparam int AW   = 2 * DBW,
   localparam int CH_W = $clog2(NCH)
) (
   input  seq_state_e      state_q,
   input  logic            to_mem_r,
   input  logic [CH_W-1:0] ch_r,
   input  logic [AW-1:0]   addr_r,
   input  logic [AW-1:0]   src_r,
   input  logic [DBW-1:0]  temp_r,
   input  logic            tc_now,
   output logic            hrq,
   output logic            aen,
   output logic            adstb,
   output logic [DBW-1:0]  db_out,
   output logic            db_oe,
   output logic [DBW-1:0]  addr_lo,
   output logic            memr_n,
   output logic            memw_n,
   output logic            ior_n,
   output logic            iow_n,
   output logic [NCH-1:0]  dack,
   output logic            eop_out_n
);

   logic norm_work, rd_side, wr_side, m2m_rd, m2m_wr, drive_tmp;

   assign norm_work = (state_q == ST_W1) || (state_q == ST_W2) ||
                      (state_q == ST_W3) || (state_q == ST_W4);
   assign rd_side   = (state_q == ST_W2) || (state_q == ST_W3) || (state_q == ST_W4);
   assign wr_side   = (state_q == ST_W3) || (state_q == ST_W4);
   assign m2m_rd    = (state_q == ST_R2) || (state_q == ST_R3) || (state_q == ST_R4);
   assign m2m_wr    = (state_q == ST_D3) || (state_q == ST_D4);
   assign drive_tmp = (state_q == ST_D2) || m2m_wr;

   assign hrq    = (state_q != ST_IDLE);
   assign aen    = is_work(state_q);
   assign adstb  = (state_q == ST_W1) || (state_q == ST_R1) || (state_q == ST_D1);
   assign db_oe  = adstb || drive_tmp;

   always_comb begin
      db_out  = '0;
      addr_lo = '0;
      if (state_q == ST_R1)      db_out = src_r[AW-1:DBW];
      else if (adstb)            db_out = addr_r[AW-1:DBW];
      else if (drive_tmp)        db_out = temp_r;
      if (state_q inside {ST_R1, ST_R2, ST_R3, ST_R4}) addr_lo = src_r[DBW-1:0];
      else if (aen)                                    addr_lo = addr_r[DBW-1:0];
   end

   assign ior_n  = !(rd_side && to_mem_r);
   assign memw_n = !((wr_side && to_mem_r) || m2m_wr);
   assign memr_n = !((rd_side && !to_mem_r) || m2m_rd);
   assign iow_n  = !(wr_side && !to_mem_r);

   assign eop_out_n = !(((state_q == ST_W4) || (state_q == ST_D4)) && tc_now);

   for (genvar i = 0; i < NCH; i++) begin : g_dack
      assign dack[i] = norm_work && (ch_r == CH_W'(i));
   end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_seq_pkg::*;
#(
   parameter int DBW = 8,
   parameter int CW  = 16,
   parameter int NCH = 4,
   localparam int AW   = 2 * DBW,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            dreq,
   input  logic [CH_W-1:0] chan,
   input  logic [1:0]      svc_mode,
   input  logic            addr_dec,
   input  logic            auto_init,
   input  logic            mem2mem,
   input  logic            to_mem,
   input  logic [AW-1:0]   cur_addr,
   input  logic [CW-1:0]   cur_cnt,
   input  logic [AW-1:0]   base_addr,
   input  logic [CW-1:0]   base_cnt,
   input  logic [AW-1:0]   src_addr,
   input  logic [AW-1:0]   src_base,
   input  logic            hlda,
   input  logic            ready,
   input  logic            eop_in_n,
   input  logic [DBW-1:0]  db_in,
   output logic            hrq,
   output logic            aen,
   output logic            adstb,
   output logic [DBW-1:0]  db_out,
   output logic            db_oe,
   output logic [DBW-1:0]  addr_lo,
   output logic            memr_n,
   output logic            memw_n,
   output logic            ior_n,
   output logic            iow_n,
   output logic [NCH-1:0]  dack,
   output logic            eop_out_n,
   output logic            wb_valid,
   output logic [CH_W-1:0] wb_ch,
   output logic [AW-1:0]   wb_addr,
   output logic [CW-1:0]   wb_cnt,
   output logic [AW-1:0]   wb_src,
   output logic            set_mask,
   output logic            set_tc
);

   if (NCH < 2) begin : g_bad_nch
      $error("dma_xfer_seq: NCH must be at least 2 for copy mode");
   end
   if (DBW < 4) begin : g_bad_dbw
      $error("dma_xfer_seq: DBW too small");
   end
   if (CW < 2) begin : g_bad_cw
      $error("dma_xfer_seq: CW too small");
   end

   seq_state_e      state_q;
   logic            ld, m2m_r, to_mem_r, tc_now, svc_end;
   logic [CH_W-1:0] ch_r;
   logic [AW-1:0]   addr_r, src_r;
   logic [DBW-1:0]  temp_r;

   dma_seq_fsm u_fsm (
      .clk(clk), .rst(rst), .dreq(dreq), .hlda(hlda), .ready(ready),
      .m2m_r(m2m_r), .svc_end(svc_end), .state_q(state_q), .ld(ld)
   );

   dma_seq_path #(.DBW(DBW), .CW(CW), .NCH(NCH)) u_path (
      .clk(clk), .rst(rst), .state_q(state_q), .ld(ld), .dreq(dreq),
      .eop_in_n(eop_in_n), .db_in(db_in), .chan(chan), .svc_mode(svc_mode),
      .addr_dec(addr_dec), .auto_init(auto_init), .mem2mem(mem2mem),
      .to_mem(to_mem), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
      .base_addr(base_addr), .base_cnt(base_cnt), .src_addr(src_addr),
      .src_base(src_base), .m2m_r(m2m_r), .to_mem_r(to_mem_r), .ch_r(ch_r),
      .addr_r(addr_r), .src_r(src_r), .temp_r(temp_r), .tc_now(tc_now),
      .svc_end(svc_end), .wb_valid(wb_valid), .wb_ch(wb_ch),
      .wb_addr(wb_addr), .wb_cnt(wb_cnt), .wb_src(wb_src),
      .set_mask(set_mask), .set_tc(set_tc)
   );

   dma_seq_pins #(.DBW(DBW), .NCH(NCH)) u_pins (
      .state_q(state_q), .to_mem_r(to_mem_r), .ch_r(ch_r), .addr_r(addr_r),
      .src_r(src_r), .temp_r(temp_r), .tc_now(tc_now), .hrq(hrq), .aen(aen),
      .adstb(adstb), .db_out(db_out), .db_oe(db_oe), .addr_lo(addr_lo),
      .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
      .dack(dack), .eop_out_n(eop_out_n)
   );

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk
   import dma_seq_pkg::*;
#(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst,
   input logic           hlda,
   input logic           ready,
   input logic           hrq,
   input logic           aen,
   input logic           adstb,
   input logic           db_oe,
   input logic           memr_n,
   input logic           memw_n,
   input logic           ior_n,
   input logic           iow_n,
   input logic [NCH-1:0] dack,
   input logic           eop_out_n,
   input logic           wb_valid,
   input logic           set_mask,
   input seq_state_e     st
);

   a_r2_aen_needs_ack: assert property (@(posedge clk) disable iff (rst)
      $rose(aen) |-> $past(hlda));

   a_r2_hrq_covers_aen: assert property (@(posedge clk) disable iff (rst)
      aen |-> hrq);

   a_r3_strobe_drives_bus: assert property (@(posedge clk) disable iff (rst)
      adstb |-> (aen && db_oe));

   a_r4_no_bus_clash: assert property (@(posedge clk) disable iff (rst)
      !(!memr_n && !memw_n) && !(!ior_n && !iow_n));

   a_r5_wait_repeats: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_W3) && !ready && !rst) |=> ((st == ST_W3) && (!ior_n || !memr_n)));

   a_r7_tc_single_pulse: assert property (@(posedge clk) disable iff (rst)
      !eop_out_n |=> (eop_out_n && wb_valid));

   a_r8_mask_with_wb: assert property (@(posedge clk) disable iff (rst)
      set_mask |-> wb_valid);

   a_r13_dack_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dack));

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst(rst), .hlda(hlda), .ready(ready), .hrq(hrq), .aen(aen),
   .adstb(adstb), .db_oe(db_oe), .memr_n(memr_n), .memw_n(memw_n),
   .ior_n(ior_n), .iow_n(iow_n), .dack(dack), .eop_out_n(eop_out_n),
   .wb_valid(wb_valid), .set_mask(set_mask), .st(state_q)
);

// File: tb/dma_xfer_seq_bench.sv
`timescale 1ns/1ps
module dma_xfer_seq_bench;

   logic        clk = 1'b0, rst = 1'b1;
   logic        dreq = 0, addr_dec = 0, auto_init = 0, mem2mem = 0, to_mem = 0;
   logic [1:0]  chan = 0, svc_mode = 0;
   logic [15:0] cur_addr = 0, cur_cnt = 0, base_addr = 0, base_cnt = 0;
   logic [15:0] src_addr = 0, src_base = 0;
   logic        hlda = 0, ready = 1, eop_in_n = 1;
   logic [7:0]  db_in = 0;
   logic        hrq, aen, adstb, db_oe, memr_n, memw_n, ior_n, iow_n, eop_out_n;
   logic [7:0]  db_out, addr_lo;
   logic [3:0]  dack;
   logic        wb_valid, set_mask, set_tc;
   logic [1:0]  wb_ch;
   logic [15:0] wb_addr, wb_cnt, wb_src;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   dma_xfer_seq u_dma_xfer_seq (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic ctx(input logic [1:0] m, input logic dec, input logic au,
                      input logic cp, input logic tm, input logic [1:0] ch,
                      input logic [15:0] a, input logic [15:0] c,
                      input logic [15:0] ba, input logic [15:0] bc,
                      input logic [15:0] sa, input logic [15:0] sb);
      svc_mode = m; addr_dec = dec; auto_init = au; mem2mem = cp; to_mem = tm;
      chan = ch; cur_addr = a; cur_cnt = c; base_addr = ba; base_cnt = bc;
      src_addr = sa; src_base = sb;
   endtask

   // runs a service with hlda high; drops dreq after transfer drop_at,
   // pulses eop_in_n in the first cycle after transfer eop_at begins
   task automatic run_svc(input int drop_at, input int eop_at,
                          output int nxf, output int neop);
      nxf = 0; neop = 0; dreq = 1; hlda = 1;
      for (int c = 0; c < 400; c++) begin
         step();
         eop_in_n = 1;
         if (adstb) begin
            nxf++;
            if (nxf == drop_at) dreq = 0;
            if (nxf == eop_at) eop_in_n = 0;
         end
         if (!eop_out_n) neop++;
         if (wb_valid) break;
      end
      dreq = 0; eop_in_n = 1;
   endtask

   task automatic t_reset();
      chk("R1 hrq", hrq, 0); chk("R1 aen", aen, 0); chk("R1 adstb", adstb, 0);
      chk("R1 db_oe", db_oe, 0);
      chk("R1 strobes", {memr_n, memw_n, ior_n, iow_n}, 4'hF);
      chk("R1 eop_out_n", eop_out_n, 1); chk("R1 dack", dack, 0);
      chk("R1 wb_valid", wb_valid, 0);
   endtask

   task automatic t_single();
      ctx(2'b01, 0, 0, 0, 1, 2'd2, 16'h12FF, 16'd5, 0, 0, 0, 0);
      hlda = 0; dreq = 1;
      step();
      chk("R2 hrq after req", hrq, 1); chk("R2 no aen before ack", aen, 0);
      step();
      chk("R2 still waiting", aen, 0);
      hlda = 1;
      step();
      chk("R3 adstb", adstb, 1); chk("R3 aen", aen, 1);
      chk("R3 upper byte", db_out, 8'h12); chk("R3 db_oe", db_oe, 1);
      chk("R3 lower byte", addr_lo, 8'hFF); chk("R3 dack", dack, 4'b0100);
      step();
      chk("R4 cyc2 read side", {ior_n, memw_n}, 2'b01);
      chk("R4 cyc2 unused strobes", {memr_n, iow_n}, 2'b11);
      step();
      chk("R4 cyc3 both", {ior_n, memw_n}, 2'b00);
      step();
      chk("R4 cyc4 both", {ior_n, memw_n}, 2'b00);
      chk("R7 no tc", eop_out_n, 1);
      step();
      dreq = 0;
      chk("R9 hrq dropped", hrq, 0); chk("R8 wb_valid", wb_valid, 1);
      chk("R6 inc addr", wb_addr, 16'h1300); chk("R6 count", wb_cnt, 16'd4);
      chk("R9 no mask", set_mask, 0); chk("R8 wb_ch", wb_ch, 2'd2);
      step();
      chk("R9 stays idle", hrq, 0);
   endtask

   task automatic t_wait();
      ctx(2'b01, 1, 0, 0, 0, 2'd0, 16'h0500, 16'd3, 0, 0, 0, 0);
      hlda = 1; dreq = 1;
      step();                       // hold
      step(); dreq = 0;             // cycle 1
      step();                       // cycle 2
      chk("R4 memr first", {memr_n, iow_n}, 2'b01);
      ready = 0;
      step();                       // cycle 3
      chk("R5 cyc3 strobes", {memr_n, iow_n}, 2'b00);
      step();
      chk("R5 wait held", {memr_n, iow_n, aen, adstb}, 4'b0010);
      step();
      chk("R5 wait held again", {memr_n, iow_n, wb_valid}, 3'b000);
      ready = 1;
      step();                       // cycle 4
      chk("R5 cycle4", {memr_n, iow_n}, 2'b00);
      step();
      chk("R5 wb after wait", wb_valid, 1);
      chk("R6 dec addr", wb_addr, 16'h04FF); chk("R6 dec count", wb_cnt, 16'd2);
      step();
   endtask

   task automatic t_block_tc();
      int nxf, neop;
      ctx(2'b10, 1, 0, 0, 1, 2'd3, 16'h4000, 16'd2, 16'h7777, 16'd9, 0, 0);
      run_svc(1, 0, nxf, neop);
      chk("R10 transfers", nxf, 3); chk("R7 eop pulses", neop, 1);
      chk("R7 wrapped count", wb_cnt, 16'hFFFF); chk("R6 addr", wb_addr, 16'h3FFD);
      chk("R8 mask", set_mask, 1); chk("R8 tc", set_tc, 1);
      step();
   endtask

   task automatic t_auto();
      int nxf, neop;
      ctx(2'b11, 0, 1, 0, 0, 2'd1, 16'h0010, 16'd0, 16'h0800, 16'd3, 0, 0);
      run_svc(1, 0, nxf, neop);
      chk("R8 one xfer", nxf, 1); chk("R7 eop", neop, 1);
      chk("R8 reload addr", wb_addr, 16'h0800); chk("R8 reload cnt", wb_cnt, 16'd3);
      chk("R8 no mask", {set_mask, set_tc}, 2'b00);
      step();
   endtask

   task automatic t_demand();
      int nxf, neop;
      ctx(2'b00, 0, 0, 0, 1, 2'd0, 16'h0100, 16'd10, 0, 0, 0, 0);
      run_svc(2, 0, nxf, neop);
      chk("R11 transfers", nxf, 2); chk("R11 no eop", neop, 0);
      chk("R11 addr", wb_addr, 16'h0102); chk("R11 cnt", wb_cnt, 16'd8);
      chk("R11 no mask", set_mask, 0);
      step();
      chk("R11 idle after", hrq, 0);
   endtask

   task automatic t_ext_eop();
      int nxf, neop;
      ctx(2'b10, 0, 0, 0, 1, 2'd1, 16'h2000, 16'd100, 0, 0, 0, 0);
      run_svc(1, 1, nxf, neop);
      chk("R12 transfers", nxf, 1); chk("R12 no eop out", neop, 0);
      chk("R12 cnt", wb_cnt, 16'd99); chk("R12 mask", {set_mask, set_tc}, 2'b11);
      step();
   endtask

   task automatic t_m2m();
      ctx(2'b10, 0, 0, 1, 0, 2'd0, 16'h2000, 16'd0, 0, 0, 16'h01F0, 0);
      hlda = 1; dreq = 1;
      step(); dreq = 0;              // hold
      step();                        // read 1
      chk("R13 src strobe", {adstb, db_out}, {1'b1, 8'h01});
      chk("R13 src low", addr_lo, 8'hF0); chk("R13 no dack", dack, 0);
      db_in = 8'hA5;
      step(); chk("R13 memr r2", memr_n, 0);
      step(); chk("R13 memr r3", memr_n, 0);
      step(); chk("R13 memr r4", {memr_n, memw_n}, 2'b01);
      step(); db_in = 8'h3C;         // write 1
      chk("R13 dst strobe", {adstb, db_out, addr_lo}, {1'b1, 8'h20, 8'h00});
      step();
      chk("R13 temp out", {db_oe, db_out, memw_n}, {1'b1, 8'hA5, 1'b1});
      step(); chk("R13 memw w3", {memw_n, memr_n}, 2'b01);
      step();
      chk("R14 eop on write end", {eop_out_n, memw_n, db_out}, {2'b00, 8'hA5});
      step();
      chk("R14 wb", wb_valid, 1); chk("R14 wb_ch", wb_ch, 2'd1);
      chk("R14 dst", wb_addr, 16'h2001); chk("R14 src", wb_src, 16'h01F1);
      chk("R14 cnt", wb_cnt, 16'hFFFF); chk("R14 mask", set_mask, 1);
      step();
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst = 0;
      step();
      t_reset();
      t_single();
      t_wait();
      t_block_tc();
      t_auto();
      t_demand();
      t_ext_eop();
      t_m2m();
      summary();
      $finish;
   end

endmodule